// File: doc/BRIEF.md
# I2C Byte-Command Master Engine

This block is a two-wire bus master run by 4-bit command codes. On each command the host presents, the engine carries out one bus primitive: a START condition, a STOP condition, sending a byte, receiving a byte and acknowledging it, or receiving a final byte without an acknowledge. A sixth code, the no-op, halts the bus clock. Any bus command starts the clock, and it then runs freely until the no-op is given. The engine samples each command on the first cycle in which `cmd_valid` is high and the engine is not busy.

Every bus operation takes up a whole number of bit slots. Each slot is four quarter periods long, with `QTR_CYCLES` system clocks in each quarter. SCL is low for the first two quarters and high for the last two. The data line is open-drain: `sda_pull_low` asks the pad to pull low, and releasing it lets the pull-up win. Four status bits are provided: an error flag, a busy flag, the acknowledge sampled from the slave, and the acknowledge the master sent. A one-cycle interrupt pulse marks the end of each bus operation.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, all four status bits read 0, `done_irq` is 0, `scl_o` is 1 and `sda_pull_low` is 0.
- R2: Code 4'b1001 (START) releases SDA while SCL is low, then pulls SDA low while SCL is high, and keeps SDA low after the operation.
- R3: Code 4'b0011 sends `tx_byte` MSB first over 8 clock pulses. On the 9th pulse SDA is released and sampled, and the sampled level goes into `stat_rx_nack`, so 0 means the slave acknowledged.
- R4: Code 4'b0010 shifts in 8 bits MSB first, sampled while SCL is high, and presents them on `rx_byte`. It then pulls SDA low during the 9th pulse and sets `stat_tx_nack` to 0.
- R5: Code 4'b0110 reads a byte in the same way as R4, but it leaves SDA released during the 9th pulse and sets `stat_tx_nack` to 1.
- R6: Code 4'b0101 (STOP) pulls SDA low while SCL is low, then releases SDA while SCL is high.
- R7: Any code outside {0000, 0010, 0011, 0101, 0110, 1001} sets `stat_err`, leaves `stat_busy` low and leaves SDA unchanged. Any accepted legal code clears `stat_err`.
- R8: After a bus command, SCL keeps toggling between commands. Code 4'b0000 raises no busy and clears `stat_err`. It also parks SCL high within one bit slot, with no further SCL edges.
- R9: `stat_busy` rises on the cycle after a bus command is accepted and falls when the operation completes. `done_irq` is a one-cycle pulse in exactly the cycles in which `stat_busy` falls.
- R10: A command presented while `stat_busy` is high is ignored. It causes no bus action and no change to `stat_err`.
- R11: While the engine is idle, SDA never changes while SCL is high. Data bits change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| tx_byte | input | 8 | Byte to transmit |
| rx_byte | output | 8 | Last byte received |
| stat_err | output | 1 | Illegal command flag |
| stat_busy | output | 1 | Bus operation in progress |
| stat_rx_nack | output | 1 | Slave acknowledge level (0 = ACK) |
| stat_tx_nack | output | 1 | Master acknowledge level (0 = ACK sent) |
| done_irq | output | 1 | One-cycle pulse when busy falls |
| scl_o | output | 1 | Bus clock |
| sda_pull_low | output | 1 | Open-drain data drive, 1 pulls low |
| sda_in | input | 1 | Data line level |

## Verification
The assertions check four things on every cycle. The interrupt pulse must coincide with the fall of busy. Bus codes must raise busy. Illegal codes must set the error flag without raising busy, and commands that arrive while busy must leave the error flag alone. SDA may move during an SCL-high phase only while an operation is in progress. The bench scenarios cover the parts that need a slave model: bit order on the wire, the acknowledge levels in both directions, and captured read data. They also show START and STOP detected as edges while SCL is high, a command ignored while busy, and the clock running freely after a bus command and stopping after the no-op.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  typedef enum logic [2:0] {
    OP_NOP, OP_START, OP_STOP, OP_TX, OP_RX_ACK, OP_RX_LAST, OP_BAD
  } op_e;

  localparam logic [3:0] CODE_NOP     = 4'b0000;
  localparam logic [3:0] CODE_RX_ACK  = 4'b0010;
  localparam logic [3:0] CODE_TX      = 4'b0011;
  localparam logic [3:0] CODE_STOP    = 4'b0101;
  localparam logic [3:0] CODE_RX_LAST = 4'b0110;
  localparam logic [3:0] CODE_START   = 4'b1001;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import i2c_eng_pkg::*;
(
  input  logic [3:0] code,
  output op_e        op
);
  always_comb begin
    unique case (code)
      CODE_NOP:     op = OP_NOP;
      CODE_RX_ACK:  op = OP_RX_ACK;
      CODE_TX:      op = OP_TX;
      CODE_STOP:    op = OP_STOP;
      CODE_RX_LAST: op = OP_RX_LAST;
      CODE_START:   op = OP_START;
      default:      op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/quarter_timer.sv
module quarter_timer #(
  parameter int QTR_CYCLES = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic       tick,
  output logic [1:0] phase,
  output logic       scl
);
  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);
  assign scl  = phase[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 2'd3;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      // a stopped clock parks in the last quarter with SCL high
      if (tick && (run || phase != 2'd3))
        phase <= phase + 2'd1;
    end
  end
endmodule

// File: rtl/byte_sequencer.sv
module byte_sequencer
  import i2c_eng_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc,
  input  op_e             acc_op,
  input  logic [BITS-1:0] tx_byte,
  input  logic            tick,
  input  logic [1:0]      phase,
  input  logic            sda_in,
  output logic            busy,
  output logic            err,
  output logic            rx_nack,
  output logic            tx_nack,
  output logic            irq,
  output logic            run,
  output logic            sda_low,
  output logic [BITS-1:0] rx_byte
);
  localparam int IW = $clog2(BITS + 1);
  localparam logic [IW-1:0] ACK_IDX = IW'(BITS);

  logic            active;
  op_e             op_r;
  logic [IW-1:0]   idx, nidx;
  logic [BITS-1:0] sh;
  logic            drv;

  wire slot_edge = tick && (phase == 2'd3);
  wire mid_high  = tick && (phase == 2'd2);
  wire rx_op     = (op_r == OP_RX_ACK) || (op_r == OP_RX_LAST);
  wire byte_op   = rx_op || (op_r == OP_TX);
  wire last_bit  = byte_op ? (idx == ACK_IDX) : 1'b1;

  // level to drive at the start of the next bit slot
  always_comb begin
    nidx = active ? idx + 1'b1 : '0;
    unique case (op_r)
      OP_STOP:   drv = 1'b1;
      OP_TX:     drv = (nidx == ACK_IDX) ? 1'b0 : ~sh[BITS-1];
      OP_RX_ACK: drv = (nidx == ACK_IDX);
      default:   drv = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; err <= 1'b0; rx_nack <= 1'b0; tx_nack <= 1'b0;
      irq <= 1'b0; run <= 1'b0; sda_low <= 1'b0; rx_byte <= '0;
      active <= 1'b0; op_r <= OP_NOP; idx <= '0; sh <= '0;
    end else begin
      irq <= 1'b0;
      if (acc) begin
        unique case (acc_op)
          OP_NOP: begin run <= 1'b0; err <= 1'b0; end
          OP_BAD: err <= 1'b1;
          default: begin
            err <= 1'b0; busy <= 1'b1; run <= 1'b1;
            op_r <= acc_op; sh <= tx_byte;
          end
        endcase
      end
      if (slot_edge) begin
        if (active) begin
          if (last_bit) begin
            active <= 1'b0; busy <= 1'b0; irq <= 1'b1;
            sda_low <= (op_r == OP_START);
          end else begin
            idx <= nidx;
            sda_low <= drv;
            if (rx_op && nidx == ACK_IDX) tx_nack <= (op_r == OP_RX_LAST);
          end
        end else if (busy) begin
          active <= 1'b1; idx <= '0; sda_low <= drv;
        end
      end
      if (mid_high && active) begin
        unique case (op_r)
          OP_START: sda_low <= 1'b1;
          OP_STOP:  sda_low <= 1'b0;
          default: begin
            if (idx < ACK_IDX) sh <= {sh[BITS-2:0], sda_in};
            if (rx_op && idx == ACK_IDX - 1'b1) rx_byte <= {sh[BITS-2:0], sda_in};
            if (op_r == OP_TX && idx == ACK_IDX) rx_nack <= sda_in;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int QTR_CYCLES = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              stat_err,
  output logic              stat_busy,
  output logic              stat_rx_nack,
  output logic              stat_tx_nack,
  output logic              done_irq,
  output logic              scl_o,
  output logic              sda_pull_low,
  input  logic              sda_in
);
  op_e        dec_op;
  logic       tick, run;
  logic [1:0] phase;

  wire acc = cmd_valid && !stat_busy;

  cmd_decode u_dec (.code(cmd_code), .op(dec_op));

  quarter_timer #(.QTR_CYCLES(QTR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .phase(phase), .scl(scl_o)
  );

  byte_sequencer #(.BITS(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .acc(acc), .acc_op(dec_op), .tx_byte(tx_byte),
    .tick(tick), .phase(phase), .sda_in(sda_in),
    .busy(stat_busy), .err(stat_err), .rx_nack(stat_rx_nack),
    .tx_nack(stat_tx_nack), .irq(done_irq), .run(run),
    .sda_low(sda_pull_low), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       stat_busy,
  input logic       stat_err,
  input logic       done_irq,
  input logic       scl_o,
  input logic       sda_pull_low
);
  wire bus_code = (cmd_code == 4'b0010) || (cmd_code == 4'b0011) ||
                  (cmd_code == 4'b0101) || (cmd_code == 4'b0110) ||
                  (cmd_code == 4'b1001);
  wire bad_code = !bus_code && (cmd_code != 4'b0000);

  AST_IRQ_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_busy) |-> done_irq); // R9
  AST_IRQ_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $fell(stat_busy)); // R9
  AST_BUS_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !stat_busy && bus_code) |=> stat_busy); // R9
  AST_BAD_CODE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !stat_busy && bad_code) |=> (stat_err && !stat_busy)); // R7
  AST_NOP_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !stat_busy && cmd_code == 4'b0000) |=> (!stat_busy && !stat_err)); // R8
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && stat_busy) |=> $stable(stat_err)); // R10
  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_o && $past(scl_o) && (sda_pull_low != $past(sda_pull_low))) |-> stat_busy); // R11
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .stat_busy(stat_busy), .stat_err(stat_err), .done_irq(done_irq),
  .scl_o(scl_o), .sda_pull_low(sda_pull_low)
);

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic       stat_err, stat_busy, stat_rx_nack, stat_tx_nack, done_irq;
  logic       scl_o, sda_pull_low;

  logic slv_low = 1'b0;
  wire  bus_sda = !(sda_pull_low || slv_low);

  int checks = 0, errors = 0;
  logic       rx_mode = 1'b0, ack_drive = 1'b0;
  logic [7:0] rd_data = 8'h00, tx_cap = 8'h00;
  logic       ninth = 1'b1;
  int bit_idx = 0, start_cnt = 0, stop_cnt = 0, scl_edges = 0, irq_cnt = 0, bad_hi = 0;
  logic scl_q = 1'b1, sda_q = 1'b1, busy_q = 1'b0;

  always #5 clk = ~clk;

  i2c_byte_engine #(.DATA_W(8), .QTR_CYCLES(4)) i_i2c_byte_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .stat_err(stat_err),
    .stat_busy(stat_busy), .stat_rx_nack(stat_rx_nack),
    .stat_tx_nack(stat_tx_nack), .done_irq(done_irq), .scl_o(scl_o),
    .sda_pull_low(sda_pull_low), .sda_in(bus_sda)
  );

  // slave model and bus monitor, sampling between clock edges
  always @(negedge clk) begin
    if (!rst) begin
      if (!busy_q && stat_busy) bit_idx = 0;
      if (scl_q && !scl_o) begin
        scl_edges++;
        if (stat_busy) begin
          if (rx_mode && bit_idx < 8) slv_low = !rd_data[7 - bit_idx];
          else if (!rx_mode && bit_idx == 8) slv_low = ack_drive;
          else slv_low = 1'b0;
          bit_idx++;
        end else slv_low = 1'b0;
      end
      if (!scl_q && scl_o) begin
        scl_edges++;
        if (stat_busy && bit_idx >= 1 && bit_idx <= 8) tx_cap = {tx_cap[6:0], bus_sda};
        if (stat_busy && bit_idx == 9) ninth = bus_sda;
      end
      if (scl_q && scl_o) begin
        if (sda_q && !bus_sda) start_cnt++;
        if (!sda_q && bus_sda) stop_cnt++;
        if (sda_q != bus_sda && !stat_busy) bad_hi++;
      end
      if (done_irq) irq_cnt++;
    end
    scl_q = scl_o; sda_q = bus_sda; busy_q = stat_busy;
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_cmd(input logic [3:0] c, input logic [7:0] d);
    @(negedge clk);
    cmd_code = c; tx_byte = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_bus_cmd(input logic [3:0] c, input logic [7:0] d);
    while (stat_busy) @(negedge clk);
    pulse_cmd(c, d);
    while (stat_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    check(stat_err == 0 && stat_busy == 0 && stat_rx_nack == 0 && stat_tx_nack == 0,
          "R1", "status", {stat_err, stat_busy, stat_rx_nack, stat_tx_nack}, 0);
    check(scl_o == 1 && sda_pull_low == 0 && done_irq == 0, "R1", "bus idle",
          {scl_o, sda_pull_low, done_irq}, 3'b100);
  endtask

  task automatic t_start;
    rx_mode = 0; ack_drive = 0;
    run_bus_cmd(4'b1001, 8'h00);
    check(start_cnt == 1, "R2", "start edges", start_cnt, 1);
    check(sda_pull_low == 1, "R2", "sda held low", sda_pull_low, 1);
    check(irq_cnt == 1, "R9", "irq pulses", irq_cnt, 1);
  endtask

  task automatic t_tx(input logic [7:0] d, input logic ack);
    rx_mode = 0; ack_drive = ack;
    run_bus_cmd(4'b0011, d);
    check(tx_cap == d, "R3", "byte on wire", tx_cap, d);
    check(stat_rx_nack == !ack, "R3", "rx_nack", stat_rx_nack, !ack);
  endtask

  task automatic t_busy_ignored;
    int stops;
    logic e0;
    rx_mode = 0; ack_drive = 1;
    stops = stop_cnt;
    pulse_cmd(4'b0011, 8'h3C);
    repeat (5) @(negedge clk);
    e0 = stat_err;
    pulse_cmd(4'b0101, 8'h00);
    check(stat_err == e0, "R10", "err unchanged", stat_err, e0);
    while (stat_busy) @(negedge clk);
    repeat (40) begin
      @(negedge clk);
      if (stat_busy) break;
    end
    check(!stat_busy && stop_cnt == stops, "R10", "no extra op", stop_cnt, stops);
    check(tx_cap == 8'h3C, "R3", "second byte", tx_cap, 8'h3C);
  endtask

  task automatic t_rx(input logic [7:0] d, input logic last);
    rx_mode = 1; rd_data = d;
    run_bus_cmd(last ? 4'b0110 : 4'b0010, 8'h00);
    rx_mode = 0;
    if (!last) begin
      check(rx_byte == d, "R4", "rx byte", rx_byte, d);
      check(ninth == 0 && stat_tx_nack == 0, "R4", "ack sent", {ninth, stat_tx_nack}, 0);
    end else begin
      check(rx_byte == d, "R5", "rx byte", rx_byte, d);
      check(ninth == 1 && stat_tx_nack == 1, "R5", "nack left", {ninth, stat_tx_nack}, 2'b11);
    end
  endtask

  task automatic t_illegal;
    logic s0;
    s0 = sda_pull_low;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      c = 4'(i);
      if (c == 4'h0 || c == 4'h2 || c == 4'h3 || c == 4'h5 || c == 4'h6 || c == 4'h9) continue;
      pulse_cmd(c, 8'h00);
      repeat (3) @(negedge clk);
      check(stat_err && !stat_busy, "R7", "err set no busy", {stat_err, stat_busy}, 2'b10);
    end
    check(sda_pull_low == s0, "R7", "sda unchanged", sda_pull_low, s0);
  endtask

  task automatic t_stop_freerun;
    run_bus_cmd(4'b0101, 8'h00);
    check(stop_cnt == 1, "R6", "stop edges", stop_cnt, 1);
    check(sda_pull_low == 0, "R6", "sda released", sda_pull_low, 0);
    check(stat_err == 0, "R7", "legal clears err", stat_err, 0);
    begin
      int e0;
      e0 = scl_edges;
      repeat (200) @(negedge clk);
      check(scl_edges > e0, "R8", "clock free-runs", scl_edges - e0, 1);
    end
  endtask

  task automatic t_nop;
    int e0;
    pulse_cmd(4'h7, 8'h00);
    pulse_cmd(4'b0000, 8'h00);
    @(negedge clk);
    check(!stat_err && !stat_busy, "R8", "nop clears err", {stat_err, stat_busy}, 0);
    repeat (40) @(negedge clk);
    e0 = scl_edges;
    repeat (200) @(negedge clk);
    check(scl_edges == e0 && scl_o == 1, "R8", "clock parked high", scl_edges - e0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start();
    t_tx(8'hA5, 1'b1);
    t_busy_ignored();
    t_tx(8'h3C, 1'b0);
    t_rx(8'h96, 1'b0);
    t_rx(8'h5B, 1'b1);
    t_illegal();
    t_stop_freerun();
    t_nop();
    check(irq_cnt == 7, "R9", "irq total", irq_cnt, 7);
    check(bad_hi == 0, "R11", "sda moved with scl high while idle", bad_hi, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule